// File: doc/BRIEF.md
# Flash Program and Erase Sequencer

This block sits on the host side of a byte-wide parallel flash device. It drives the chip enable, write strobe, output enable, address and data lines to carry out two jobs. The first is to program one byte. The second is to erase the whole array and confirm that every byte reads back as erased. A single `start` pulse, with `op_erase` picking the job, launches the work. The target address and data are captured at that moment. The block then emits the command writes, waits out the programming or erase pulse, issues the verify command and compares what the device returns.

When a byte fails to program, the whole program sequence repeats for the same byte. When erase verify finds a byte that is not erased, the block fires a fresh erase pulse and resumes verifying at that same address. Both kinds of pulse are counted against parameterised limits. Once the job passes or gives up, the block writes the reset command twice to put the flash back in read mode. It then pulses `done`, and `fail` qualifies the outcome. Pulse waits and strobe width are counted in clock cycles.

Top module: `flash_seq`

## Requirements
- R1: Out of reset, `flash_ce_n`, `flash_we_n` and `flash_oe_n` are high, and `flash_dq_oe`, `busy`, `done` and `fail` are low.
- R2: Every bus write pulls `flash_ce_n` low one cycle before `flash_we_n` falls. It holds `flash_we_n` low for `WE_LOW` cycles, keeps address and data steady while the strobe is low, and keeps them one cycle past its rise. `flash_we_n` and `flash_oe_n` are never low together, and neither is low while `flash_ce_n` is high.
- R3: A program attempt, with every bus access at the captured address, is: write 40h, write the data byte, keep `flash_we_n` high for at least `PROG_WAIT` cycles, write C0h, then read one byte.
- R4: If the byte read after C0h equals the captured data, the job ends without failure. Otherwise the full attempt of R3 repeats for the same byte.
- R5: Each data write of R3 counts as one program pulse. A mismatch after pulse number `MAX_PROG` ends the job with `fail` set.
- R6: An erase pulse is two writes of 20h. `flash_we_n` then stays high for at least `ERASE_WAIT` cycles. Verification follows as pairs of a write of A0h and a read, both at the verify address. Pulse commands are issued at the current verify address, which starts at 0.
- R7: A verify read of FFh moves the verify address up by one. Erase completes after the highest address reads FFh. Any other value triggers a new erase pulse, and verification resumes at the same failing address, not at 0.
- R8: Each erase pulse is counted. A failing verify read after pulse number `MAX_ERASE` ends the job with `fail` set.
- R9: Every job ends with two writes of FFh, after which `done` is high for exactly one cycle and `busy` falls. `fail` is high only in that cycle, and only for a failed job.
- R10: A `start` pulse while `busy` is high has no effect on the running job's bus traffic.

Ports are listed below in the order of the port list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch a job when idle |
| op_erase | input | 1 | 1 = erase whole array, 0 = program one byte |
| addr_in | input | AW | Byte address for program |
| data_in | input | 8 | Byte value for program |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle end-of-job pulse |
| fail | output | 1 | Job failed, valid with `done` |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_we_n | output | 1 | Flash write strobe, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_addr | output | AW | Flash address |
| flash_dq_out | output | 8 | Data driven to flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_out` |
| flash_dq_in | input | 8 | Data returned by flash |

## Verification
Two decisions land in the same verify-read cycle: the compare that asks for a retry and the limit check that asks to stop. The bench provokes this with a flash model that withholds success for exactly one pulse fewer than the limit in one run, and exactly up to the limit in the next. It then judges the full logged bus trace and the `fail` bit against a behavioural expectation. An erase case makes two addresses need extra pulses. Its trace shows verification restarting at each failing address, and that run passes only on the last permitted pulse.

// File: rtl/flash_seq.sv
module flash_seq #(
  parameter int AW         = 3,
  parameter int WE_LOW     = 2,
  parameter int PROG_WAIT  = 8,
  parameter int ERASE_WAIT = 20,
  parameter int MAX_PROG   = 4,
  parameter int MAX_ERASE  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          op_erase,
  input  logic [AW-1:0] addr_in,
  input  logic [7:0]    data_in,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic          flash_ce_n,
  output logic          flash_we_n,
  output logic          flash_oe_n,
  output logic [AW-1:0] flash_addr,
  output logic [7:0]    flash_dq_out,
  output logic          flash_dq_oe,
  input  logic [7:0]    flash_dq_in
);
  localparam int WMAX = (ERASE_WAIT > PROG_WAIT) ? ERASE_WAIT : PROG_WAIT;
  localparam int CW   = $clog2(WMAX + WE_LOW + 2);
  localparam int LMAX = (MAX_ERASE > MAX_PROG) ? MAX_ERASE : MAX_PROG;
  localparam int NW   = $clog2(LMAX + 1);
  localparam logic [AW-1:0] TOP = '1;

  typedef enum logic [3:0] {
    IDLE, P_SET, P_DAT, P_WAIT, P_VER, P_RD,
    E_SET, E_GO, E_WAIT, E_VER, E_RD, R_ONE, R_TWO
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [AW-1:0] a_q, va_q;
  logic [7:0]    d_q;
  logic [NW-1:0] pulses;
  logic          bad, is_er;
  logic          is_wr, is_rd, is_wt, step_end;
  logic [CW-1:0] wt_len;

  assign is_wr    = st inside {P_SET, P_DAT, P_VER, E_SET, E_GO, E_VER, R_ONE, R_TWO};
  assign is_rd    = st inside {P_RD, E_RD};
  assign is_wt    = st inside {P_WAIT, E_WAIT};
  assign wt_len   = (st == E_WAIT) ? CW'(ERASE_WAIT) : CW'(PROG_WAIT);
  assign step_end = is_wr ? (cnt == CW'(WE_LOW + 1)) :
                    is_rd ? (cnt == CW'(1)) :
                    is_wt ? (cnt == wt_len - 1'b1) : 1'b0;

  assign busy        = (st != IDLE);
  assign fail        = done & bad;
  assign flash_ce_n  = !(is_wr || is_rd);
  assign flash_we_n  = !(is_wr && cnt != '0 && cnt <= CW'(WE_LOW));
  assign flash_oe_n  = !is_rd;
  assign flash_dq_oe = is_wr;
  assign flash_addr  = is_er ? va_q : a_q;

  always_comb begin
    case (st)
      P_SET:        flash_dq_out = 8'h40;
      P_DAT:        flash_dq_out = d_q;
      P_VER:        flash_dq_out = 8'hC0;
      E_SET, E_GO:  flash_dq_out = 8'h20;
      E_VER:        flash_dq_out = 8'hA0;
      default:      flash_dq_out = 8'hFF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; a_q <= '0; va_q <= '0; d_q <= '0;
      pulses <= '0; bad <= 1'b0; is_er <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == IDLE) begin
        if (start) begin
          st     <= op_erase ? E_SET : P_SET;
          a_q    <= addr_in;
          d_q    <= data_in;
          is_er  <= op_erase;
          va_q   <= '0;
          pulses <= '0;
          bad    <= 1'b0;
          cnt    <= '0;
        end
      end else if (!step_end) begin
        cnt <= cnt + 1'b1;
      end else begin
        cnt <= '0;
        case (st)
          P_SET:  st <= P_DAT;
          P_DAT:  begin st <= P_WAIT; pulses <= pulses + 1'b1; end
          P_WAIT: st <= P_VER;
          P_VER:  st <= P_RD;
          P_RD:
            if (flash_dq_in == d_q) st <= R_ONE;
            else if (pulses == NW'(MAX_PROG)) begin bad <= 1'b1; st <= R_ONE; end
            else st <= P_SET;
          E_SET:  st <= E_GO;
          E_GO:   begin st <= E_WAIT; pulses <= pulses + 1'b1; end
          E_WAIT: st <= E_VER;
          E_VER:  st <= E_RD;
          E_RD:
            if (flash_dq_in == 8'hFF) begin
              if (va_q == TOP) st <= R_ONE;
              else begin va_q <= va_q + 1'b1; st <= E_VER; end
            end
            else if (pulses == NW'(MAX_ERASE)) begin bad <= 1'b1; st <= R_ONE; end
            else st <= E_SET;
          R_ONE:  st <= R_TWO;
          R_TWO:  begin st <= IDLE; done <= 1'b1; end
          default: st <= IDLE;
        endcase
      end
    end
  end

  // R2
  bus_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!flash_we_n && !flash_oe_n));

  // R2
  we_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flash_we_n) |-> ($past(!flash_ce_n) && $stable(flash_addr)));

  // R2
  we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_we_n && $past(!flash_we_n)) |-> ($stable(flash_addr) && $stable(flash_dq_out)));

  // R5 R8
  pulse_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pulses <= NW'(LMAX));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);

  // R9
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
endmodule

// File: tb/test_flash_seq.sv
`timescale 1ns/1ps
module test_flash_seq;
  localparam int AW = 3, WE_LOW = 2, PROG_WAIT = 8, ERASE_WAIT = 20;
  localparam int MAX_PROG = 4, MAX_ERASE = 3;
  localparam int NB = 1 << AW;

  logic clk = 0, rst_n = 0, start = 0, op_erase = 0;
  logic [AW-1:0] addr_in = '0;
  logic [7:0] data_in = '0;
  logic busy, done, fail, flash_ce_n, flash_we_n, flash_oe_n, flash_dq_oe;
  logic [AW-1:0] flash_addr;
  logic [7:0] flash_dq_out, flash_dq_in;

  always #4 clk = ~clk;

  flash_seq #(.AW(AW), .WE_LOW(WE_LOW), .PROG_WAIT(PROG_WAIT), .ERASE_WAIT(ERASE_WAIT),
              .MAX_PROG(MAX_PROG), .MAX_ERASE(MAX_ERASE)) i_flash_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .op_erase(op_erase), .addr_in(addr_in),
    .data_in(data_in), .busy(busy), .done(done), .fail(fail), .flash_ce_n(flash_ce_n),
    .flash_we_n(flash_we_n), .flash_oe_n(flash_oe_n), .flash_addr(flash_addr),
    .flash_dq_out(flash_dq_out), .flash_dq_oe(flash_dq_oe), .flash_dq_in(flash_dq_in));

  int nchk = 0, nfail = 0;
  logic [7:0] mem [NB];
  int stuck [NB];
  int prog_bad = 0;
  logic [7:0] pend = 8'h00;
  int log_q [$];
  int exp_q [$];

  assign flash_dq_in = mem[flash_addr];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int wr_e(input int a, input int d);
    return 32'h1000 | (a << 8) | d;
  endfunction
  function automatic int rd_e(input int a);
    return 32'h2000 | (a << 8);
  endfunction

  // bus monitor, flash model and per-clock checks
  logic p_we = 1, p_oe = 1, p_done = 0;
  logic [AW-1:0] p_addr = '0;
  int hi_cnt = 0, last_pulse = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(!flash_we_n && !flash_oe_n), "R2 we/oe overlap", 0, 1);
      chk(!((!flash_we_n || !flash_oe_n) && flash_ce_n), "R2 strobe without ce", 1, 0);
      if (!flash_we_n && !p_we) chk(flash_addr == p_addr, "R2 addr hold", flash_addr, p_addr);
      if (!flash_we_n) chk(flash_dq_oe, "R2 dq drive", 0, 1);
      if (done && p_done) chk(0, "R9 done width", 2, 1);
      if (flash_we_n) hi_cnt++;
      if (p_we && !flash_we_n) begin
        if (last_pulse == 1) chk(hi_cnt >= PROG_WAIT, "R3 program wait", hi_cnt, PROG_WAIT);
        if (last_pulse == 2) chk(hi_cnt >= ERASE_WAIT, "R6 erase wait", hi_cnt, ERASE_WAIT);
        last_pulse = 0;
      end
      if (!p_we && flash_we_n) begin
        log_q.push_back(wr_e(flash_addr, flash_dq_out));
        hi_cnt = 1;
        if (pend == 8'h40) begin
          if (prog_bad > 0) begin mem[flash_addr] = flash_dq_out ^ 8'h01; prog_bad--; end
          else mem[flash_addr] = flash_dq_out;
          pend = 8'h00; last_pulse = 1;
        end else if (pend == 8'h20 && flash_dq_out == 8'h20) begin
          for (int a = 0; a < NB; a++)
            if (stuck[a] > 0) stuck[a]--; else mem[a] = 8'hFF;
          pend = 8'h00; last_pulse = 2;
        end else pend = flash_dq_out;
      end
      if (p_oe && !flash_oe_n) log_q.push_back(rd_e(flash_addr));
    end
    p_we = flash_we_n; p_oe = flash_oe_n; p_addr = flash_addr; p_done = done;
  end

  task automatic build_prog(input int a, input int d, input int bad, output bit ef);
    exp_q.delete();
    ef = 0;
    for (int p = 1; ; p++) begin
      exp_q.push_back(wr_e(a, 8'h40)); exp_q.push_back(wr_e(a, d));
      exp_q.push_back(wr_e(a, 8'hC0)); exp_q.push_back(rd_e(a));
      if (p > bad) break;
      if (p == MAX_PROG) begin ef = 1; break; end
    end
    exp_q.push_back(wr_e(a, 8'hFF)); exp_q.push_back(wr_e(a, 8'hFF));
  endtask

  task automatic build_erase(output bit ef);
    logic [7:0] sm [NB];
    int ss [NB];
    int va = 0, pulses = 0;
    bit fin = 0;
    for (int a = 0; a < NB; a++) begin sm[a] = mem[a]; ss[a] = stuck[a]; end
    exp_q.delete();
    ef = 0;
    while (!fin) begin
      pulses++;
      exp_q.push_back(wr_e(va, 8'h20)); exp_q.push_back(wr_e(va, 8'h20));
      for (int a = 0; a < NB; a++) if (ss[a] > 0) ss[a]--; else sm[a] = 8'hFF;
      for (int v = va; v < NB; v++) begin
        exp_q.push_back(wr_e(v, 8'hA0)); exp_q.push_back(rd_e(v));
        if (sm[v] != 8'hFF) begin
          va = v;
          if (pulses == MAX_ERASE) begin ef = 1; fin = 1; end
          break;
        end
        if (v == NB - 1) begin va = v; fin = 1; end
      end
    end
    exp_q.push_back(wr_e(va, 8'hFF)); exp_q.push_back(wr_e(va, 8'hFF));
  endtask

  task automatic run_op(input bit er, input int a, input int d, input bit ef,
                        input int poke, input string req);
    bit got = 0;
    log_q.delete();
    @(negedge clk);
    op_erase = er; addr_in = AW'(a); data_in = 8'(d); start = 1;
    @(negedge clk);
    start = 0;
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (poke != 0 && c == poke) begin
        chk(busy, "R10 busy before poke", busy, 1);
        op_erase = ~er; addr_in = AW'(a + 1); start = 1;
      end else start = 0;
      if (done) begin got = 1; break; end
    end
    start = 0;
    if (!got) chk(0, {req, " watchdog"}, 0, 1);
    else begin
      chk(fail == ef, {req, " fail flag"}, fail, ef);
      @(negedge clk);
      chk(!busy && !done, "R9 idle after done", {busy, done}, 0);
      chk(log_q.size() == exp_q.size(), {req, " trace length"}, log_q.size(), exp_q.size());
      for (int i = 0; i < exp_q.size() && i < log_q.size(); i++)
        chk(log_q[i] == exp_q[i], {req, " trace entry"}, log_q[i], exp_q[i]);
    end
  endtask

  initial begin : wdog
    #(200000 * 8);
    nfail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    bit ef;
    for (int a = 0; a < NB; a++) begin mem[a] = 8'h00; stuck[a] = 0; end
    repeat (3) @(negedge clk);
    // R1
    chk(flash_ce_n && flash_we_n && flash_oe_n, "R1 strobes in reset", {flash_ce_n, flash_we_n, flash_oe_n}, 7);
    chk(!flash_dq_oe && !busy && !done && !fail, "R1 status in reset", {flash_dq_oe, busy, done, fail}, 0);
    rst_n = 1;
    @(negedge clk);
    chk(flash_ce_n && !busy, "R1 idle after reset", {flash_ce_n, busy}, 2);

    // R3 R4 clean program
    prog_bad = 0; build_prog(5, 8'h3C, 0, ef); run_op(0, 5, 8'h3C, ef, 0, "R3 R4 program");
    // R4 retries
    prog_bad = 2; build_prog(2, 8'hA5, 2, ef); run_op(0, 2, 8'hA5, ef, 0, "R4 retry");
    // R5 passes on last allowed pulse
    prog_bad = MAX_PROG - 1; build_prog(7, 8'h5A, MAX_PROG - 1, ef);
    run_op(0, 7, 8'h5A, ef, 0, "R5 last pulse pass");
    // R5 limit exceeded
    prog_bad = MAX_PROG; build_prog(1, 8'h81, MAX_PROG, ef);
    run_op(0, 1, 8'h81, ef, 0, "R5 limit fail");
    prog_bad = 0;

    // R6 R7 clean erase
    for (int a = 0; a < NB; a++) begin mem[a] = 8'h00; stuck[a] = 0; end
    build_erase(ef); run_op(1, 0, 0, ef, 0, "R6 R7 erase");
    // R7 resume from failing address, R8 pass on last pulse
    for (int a = 0; a < NB; a++) begin mem[a] = 8'h00; stuck[a] = 0; end
    stuck[3] = 1; stuck[6] = 2;
    build_erase(ef); run_op(1, 0, 0, ef, 0, "R7 R8 resume");
    // R8 limit exceeded
    for (int a = 0; a < NB; a++) begin mem[a] = 8'h00; stuck[a] = 0; end
    stuck[0] = MAX_ERASE;
    build_erase(ef); run_op(1, 0, 0, ef, 0, "R8 erase fail");
    for (int a = 0; a < NB; a++) stuck[a] = 0;

    // R10 start while busy ignored
    prog_bad = 1; build_prog(4, 8'h66, 1, ef); run_op(0, 4, 8'h66, ef, 10, "R10 start ignored");

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule